// File: doc/BRIEF.md
# Timer Count-Clock Edge Selector

This block turns the count-clock source picked for one timer channel into a count-enable pulse that lasts one system-clock cycle. The source can be a slow internal clock derived from the system clock, the undivided system clock, or the overflow pulse of a neighbouring channel. For the slow clock, the source level is synchronized into the system clock domain. An enable is then produced on its rising edges, on its falling edges, or on both, as the edge field of an 8-bit control register selects. Counting on both edges halves the effective count period.

The edge field only matters for the slow internal clock. The undivided clock gives an enable on every cycle. A cascade source passes its overflow pulse straight through. When phase-counting mode is active on a channel that supports it, the enable comes from the phase decoder's step pulse and the edge field has no effect. The control register also holds the clear-source and prescaler fields, which other logic decodes. A write to the register is accepted only while the channel is stopped. A 16-bit up-counter driven by the enable is included so the enable can be observed as a count.

Top module: `cntclk_edge_sel`

## Requirements
- R1: While `rst_n` is low, `ctl_q_o` is 0x00, `wr_err_o` is 0, `count_o` is 0 and `ovf_o` is 0. The three-deep source history is cleared as well.
- R2: A write with `run_i` low stores `ctl_wdata_i` into `ctl_q_o` at the next clock edge. The field layout is bits 7:5 clear source, bits 4:3 clock edge and bits 2:0 prescaler.
- R3: A write with `run_i` high leaves `ctl_q_o` unchanged and sets `wr_err_o`. `wr_err_o` then stays 1 until reset.
- R4: With source kind 1 (slow internal clock) and edge field 00, `cnt_en_o` is high for exactly the cycle after the second clock edge that follows a low-to-high change of `src_clk_i`. The edge at which `src_clk_i` is first sampled high is counted as the first of the three edges. The count therefore changes at the third edge.
- R5: With source kind 1 and edge field 01, the same timing as R4 applies to high-to-low changes only.
- R6: With source kind 1 and edge field 10 or 11, both kinds of change give a pulse, so a source toggling every N cycles gives one enable every N cycles.
- R7: With source kind 0 (undivided clock), `cnt_en_o` is high on every cycle in which `run_i` is high, whatever the edge field holds.
- R8: With source kind 2 (cascade), `cnt_en_o` equals `cascade_pulse_i` in the same cycle, whatever the edge field holds.
- R9: On a channel whose CHANNEL_ID is 1 or 2, `phase_mode_i` high makes `cnt_en_o` equal `phase_step_i` and overrides the source kind and the edge field. On any other channel, `phase_mode_i` is ignored.
- R10: While `run_i` is low, `cnt_en_o` is 0 and `count_o` holds. Source kind 3 never gives an enable.
- R11: `count_o` rises by one at each clock edge where `cnt_en_o` is high. It wraps from 0xFFFF to 0x0000, and `ovf_o` is high for the single cycle that follows the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously by the surrounding logic |
| run_i | input | 1 | Channel running; gates the enable and blocks control writes |
| src_clk_i | input | 1 | Level of the selected count-clock source |
| src_kind_i | input | 2 | Source kind: 0 undivided, 1 slow internal, 2 cascade, 3 none |
| cascade_pulse_i | input | 1 | One-cycle overflow pulse from the neighbouring channel |
| phase_mode_i | input | 1 | Phase-counting mode active |
| phase_step_i | input | 1 | Count step from the phase decoder |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_q_o | output | 8 | Control register contents |
| wr_err_o | output | 1 | Sticky flag: a write was attempted while running |
| cnt_en_o | output | 1 | Count enable for the channel's counter |
| count_o | output | 16 | Counter value |
| ovf_o | output | 1 | One-cycle wrap indication |

## Verification
The bench drives the source toggling every cycle. A detector that looked at the raw input, or at only one synchronized sample, would then show a latency other than three edges and miss or duplicate pulses. The bench sweeps both encodings of the both-edges field, because a decoder that tested only value 10 would count rising edges alone with 11. It leaves a falling-edge field in place when it switches to the undivided and cascade sources, so a selector that still applied the edge field there would drop enables. It runs a second channel outside the phase-capable set, where an unconditional phase override would show up. Finally, a write while running and a full 65536-count wrap catch a register that accepts the write or an overflow flag that lasts two cycles or fires at the wrong value.

// File: rtl/cesel_pkg.sv
package cesel_pkg;

  localparam int CTL_W    = 8;
  localparam int CLR_LSB  = 5;
  localparam int CLR_W    = 3;
  localparam int EDGE_LSB = 3;
  localparam int EDGE_W   = 2;
  localparam int PSC_LSB  = 0;
  localparam int PSC_W    = 3;

  typedef enum logic [1:0] {
    SRC_FULL = 2'd0,
    SRC_DIV  = 2'd1,
    SRC_CASC = 2'd2,
    SRC_NONE = 2'd3
  } src_kind_e;

  typedef enum logic [1:0] {
    EDG_RISE = 2'd0,
    EDG_FALL = 2'd1,
    EDG_BOTH = 2'd2
  } edge_mode_e;

  function automatic edge_mode_e decode_edge(input logic [EDGE_W-1:0] fld);
    if (fld[1])      return EDG_BOTH;
    else if (fld[0]) return EDG_FALL;
    else             return EDG_RISE;
  endfunction

endpackage

// File: rtl/cesel_ctl_reg.sv
module cesel_ctl_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic         run_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic         err_o
);

  logic [W-1:0] ctl_q, ctl_d;
  logic         ctl_en;
  logic         err_q, err_d;

  // Write accepted only while the channel is stopped; a blocked write latches the error.
  always_comb begin
    ctl_en = we_i & ~run_i;
    ctl_d  = wdata_i;
    err_d  = err_q | (we_i & run_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign q_o   = ctl_q;
  assign err_o = err_q;

endmodule

// File: rtl/cesel_edge_det.sv
module cesel_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] pipe_q, pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], lvl_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  // Compare the last synchronized sample with the history flop.
  assign rise_o =  pipe_q[DEPTH-2] & ~pipe_q[DEPTH-1];
  assign fall_o = ~pipe_q[DEPTH-2] &  pipe_q[DEPTH-1];

endmodule

// File: rtl/cesel_en_mux.sv
module cesel_en_mux
  import cesel_pkg::*;
#(
  parameter bit PHASE_OK = 1'b1
) (
  input  logic       run_i,
  input  logic       phase_mode_i,
  input  logic       phase_step_i,
  input  src_kind_e  kind_i,
  input  edge_mode_e edge_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       cascade_i,
  output logic       en_o
);

  logic phase_sel;
  logic edge_hit;
  logic src_en;

  generate
    if (PHASE_OK) begin : g_phase
      assign phase_sel = phase_mode_i;
    end else begin : g_nophase
      assign phase_sel = 1'b0;
    end
  endgenerate

  always_comb begin
    case (edge_i)
      EDG_RISE: edge_hit = rise_i;
      EDG_FALL: edge_hit = fall_i;
      default:  edge_hit = rise_i | fall_i;
    endcase
  end

  always_comb begin
    case (kind_i)
      SRC_FULL: src_en = 1'b1;
      SRC_DIV:  src_en = edge_hit;
      SRC_CASC: src_en = cascade_i;
      default:  src_en = 1'b0;
    endcase
  end

  always_comb begin
    if (!run_i)         en_o = 1'b0;
    else if (phase_sel) en_o = phase_step_i;
    else                en_o = src_en;
  end

endmodule

// File: rtl/cesel_counter.sv
module cesel_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
    ovf_d = en_i & (cnt_q == TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

endmodule

// File: rtl/cntclk_edge_sel.sv
module cntclk_edge_sel
  import cesel_pkg::*;
#(
  parameter int CHANNEL_ID  = 1,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             src_clk_i,
  input  logic [1:0]       src_kind_i,
  input  logic             cascade_pulse_i,
  input  logic             phase_mode_i,
  input  logic             phase_step_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_q_o,
  output logic             wr_err_o,
  output logic             cnt_en_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);

  localparam bit PHASE_OK = (CHANNEL_ID == 1) || (CHANNEL_ID == 2);

  logic [CTL_W-1:0] ctl_q;
  logic             rise, fall;
  logic             en;
  edge_mode_e       edge_mode;

  cesel_ctl_reg #(.W(CTL_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ctl_we_i),
    .run_i   (run_i),
    .wdata_i (ctl_wdata_i),
    .q_o     (ctl_q),
    .err_o   (wr_err_o)
  );

  cesel_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (src_clk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign edge_mode = decode_edge(ctl_q[EDGE_LSB +: EDGE_W]);

  cesel_en_mux #(.PHASE_OK(PHASE_OK)) u_mux (
    .run_i        (run_i),
    .phase_mode_i (phase_mode_i),
    .phase_step_i (phase_step_i),
    .kind_i       (src_kind_e'(src_kind_i)),
    .edge_i       (edge_mode),
    .rise_i       (rise),
    .fall_i       (fall),
    .cascade_i    (cascade_pulse_i),
    .en_o         (en)
  );

  cesel_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en),
    .cnt_o (count_o),
    .ovf_o (ovf_o)
  );

  assign ctl_q_o  = ctl_q;
  assign cnt_en_o = en;

endmodule

// File: rtl/cesel_chk.sv
module cesel_chk #(
  parameter int CHANNEL_ID = 1,
  parameter int CNT_W      = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_i,
  input logic             src_clk_i,
  input logic [1:0]       src_kind_i,
  input logic             cascade_pulse_i,
  input logic             phase_mode_i,
  input logic             phase_step_i,
  input logic             ctl_we_i,
  input logic [7:0]       ctl_q_o,
  input logic             wr_err_o,
  input logic             cnt_en_o,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o
);

  localparam bit PHASE_OK = (CHANNEL_ID == 1) || (CHANNEL_ID == 2);

  logic [1:0] age_q;
  logic       ph_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign ph_act = PHASE_OK && phase_mode_i;

  // R3
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we_i && run_i) |=> ($stable(ctl_q_o) && wr_err_o));

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |=> wr_err_o);

  // R10
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> (!cnt_en_o ##1 $stable(count_o)));

  // R7
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !ph_act && src_kind_i == 2'd0) |-> cnt_en_o);

  // R8
  casc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !ph_act && src_kind_i == 2'd2) |-> (cnt_en_o == cascade_pulse_i));

  // R9
  phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && ph_act) |-> (cnt_en_o == phase_step_i));

  // R4
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && run_i && !ph_act && src_kind_i == 2'd1 && ctl_q_o[4:3] == 2'b00)
      |-> (cnt_en_o == ($past(src_clk_i, 2) && !$past(src_clk_i, 3))));

  // R11
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (count_o == '0));

  // R11
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_o |=> (count_o == CNT_W'($past(count_o) + 1)));

endmodule

bind cntclk_edge_sel cesel_chk #(.CHANNEL_ID(CHANNEL_ID), .CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .run_i           (run_i),
  .src_clk_i       (src_clk_i),
  .src_kind_i      (src_kind_i),
  .cascade_pulse_i (cascade_pulse_i),
  .phase_mode_i    (phase_mode_i),
  .phase_step_i    (phase_step_i),
  .ctl_we_i        (ctl_we_i),
  .ctl_q_o         (ctl_q_o),
  .wr_err_o        (wr_err_o),
  .cnt_en_o        (cnt_en_o),
  .count_o         (count_o),
  .ovf_o           (ovf_o)
);

// File: tb/test_cntclk_edge_sel.sv
module test_cntclk_edge_sel;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, run, src, casc, pmode, pstep, we;
  logic [1:0] kind;
  logic [7:0] wdata;

  logic [7:0]  ctl_q, ctl_q3;
  logic        err, err3, en, en3, ovf, ovf3;
  logic [15:0] cnt, cnt3;

  cntclk_edge_sel #(.CHANNEL_ID(1)) i_cntclk_edge_sel (
    .clk(clk), .rst_n(rst_n), .run_i(run), .src_clk_i(src), .src_kind_i(kind),
    .cascade_pulse_i(casc), .phase_mode_i(pmode), .phase_step_i(pstep),
    .ctl_we_i(we), .ctl_wdata_i(wdata), .ctl_q_o(ctl_q), .wr_err_o(err),
    .cnt_en_o(en), .count_o(cnt), .ovf_o(ovf));

  cntclk_edge_sel #(.CHANNEL_ID(3)) i_cntclk_edge_sel_ch3 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .src_clk_i(src), .src_kind_i(kind),
    .cascade_pulse_i(casc), .phase_mode_i(pmode), .phase_step_i(pstep),
    .ctl_we_i(we), .ctl_wdata_i(wdata), .ctl_q_o(ctl_q3), .wr_err_o(err3),
    .cnt_en_o(en3), .count_o(cnt3), .ovf_o(ovf3));

  // Reference model state
  logic [7:0]  m_ctl;
  logic        m_err, m_ovf;
  int unsigned m_cnt;
  logic        smp[$] = '{1'b0, 1'b0, 1'b0};

  int    vectors = 0, miscompares = 0, ovfs = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  function automatic logic m_en(bit ph_ok);
    logic r, f, hit;
    if (!run) return 1'b0;
    if (ph_ok && pmode) return pstep;
    r = smp[1] & ~smp[2];
    f = ~smp[1] & smp[2];
    case (m_ctl[4:3])
      2'b00:   hit = r;
      2'b01:   hit = f;
      default: hit = r | f;
    endcase
    case (kind)
      2'd0:    return 1'b1;
      2'd1:    return hit;
      2'd2:    return casc;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic e;
    e = m_en(1'b1);
    if (!rst_n) begin
      m_ctl = 8'h00; m_err = 1'b0; m_cnt = 0; m_ovf = 1'b0;
      smp = '{1'b0, 1'b0, 1'b0};
    end else begin
      m_ovf = e && (m_cnt == 65535);
      if (e) m_cnt = (m_cnt + 1) % 65536;
      if (we) begin
        if (run) m_err = 1'b1;
        else     m_ctl = wdata;
      end
      smp.push_front(src);
      void'(smp.pop_back());
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    vectors++;
    chk("ctl_q", {24'd0, ctl_q}, {24'd0, m_ctl});
    chk("wr_err", {31'd0, err}, {31'd0, m_err});
    chk("cnt_en", {31'd0, en}, {31'd0, m_en(1'b1)});
    chk("count", {16'd0, cnt}, m_cnt);
    chk("ovf", {31'd0, ovf}, {31'd0, m_ovf});
    chk("cnt_en ch3", {31'd0, en3}, {31'd0, m_en(1'b0)});
  endtask

  task automatic cycles(int n);
    repeat (n) step();
  endtask

  task automatic toggle_src(int half, int periods);
    for (int p = 0; p < periods; p++) begin
      src = 1'b1; cycles(half);
      src = 1'b0; cycles(half);
    end
  endtask

  task automatic wr(logic [7:0] v);
    we = 1'b1; wdata = v;
    step();
    we = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; src = 1'b0; casc = 1'b0; pmode = 1'b0;
    pstep = 1'b0; we = 1'b0; kind = 2'd1; wdata = 8'h00;

    // R1 reset state
    cur_req = "R1";
    cycles(3);
    chk("reset ctl", {24'd0, ctl_q}, 32'h0);
    chk("reset count", {16'd0, cnt}, 32'h0);
    rst_n = 1'b1;
    cycles(2);

    // R2 field layout: 0x5A -> clear 010, edge 11, prescaler 010
    cur_req = "R2";
    wr(8'hA5);
    wr(8'h5A);
    chk("clear field", {29'd0, ctl_q[7:5]}, 32'h2);
    chk("edge field", {30'd0, ctl_q[4:3]}, 32'h3);
    chk("prescaler field", {29'd0, ctl_q[2:0]}, 32'h2);

    // R4 rising edges, slow and every-cycle toggling
    cur_req = "R4";
    wr(8'h02);
    run = 1'b1;
    toggle_src(4, 6);
    toggle_src(3, 3);
    toggle_src(1, 6);

    // R3 write while running is blocked and sticky
    cur_req = "R3";
    wr(8'hFF);
    cycles(2);
    chk("blocked write err", {31'd0, err}, 32'h1);
    chk("blocked write ctl", {24'd0, ctl_q}, 32'h02);

    // R5 falling edges
    cur_req = "R5";
    run = 1'b0; cycles(1);
    wr(8'h08);
    run = 1'b1;
    toggle_src(3, 5);
    toggle_src(1, 4);

    // R6 both edges, both encodings
    cur_req = "R6";
    run = 1'b0; wr(8'h10); run = 1'b1;
    toggle_src(3, 4);
    run = 1'b0; wr(8'h18); run = 1'b1;
    toggle_src(2, 4);
    toggle_src(1, 4);

    // R7 undivided clock with falling-edge field left in place
    cur_req = "R7";
    run = 1'b0; wr(8'h08); run = 1'b1;
    kind = 2'd0;
    toggle_src(3, 3);

    // R8 cascade
    cur_req = "R8";
    kind = 2'd2;
    for (int i = 0; i < 40; i++) begin
      casc = (i % 3 == 0) || (i % 7 == 1);
      src = i[2];
      step();
    end
    casc = 1'b0;

    // R9 phase mode: ch1 follows step, ch3 ignores the flag
    cur_req = "R9";
    kind = 2'd1; pmode = 1'b1;
    for (int i = 0; i < 40; i++) begin
      src = ((i / 3) % 2) == 1;
      pstep = (i % 5 == 2);
      step();
    end
    pmode = 1'b0; pstep = 1'b0;

    // R10 stopped, and kind 3 never enables
    cur_req = "R10";
    run = 1'b0; kind = 2'd0;
    cycles(10);
    kind = 2'd1;
    toggle_src(2, 3);
    run = 1'b1; kind = 2'd3;
    toggle_src(2, 3);

    // R11 wrap with the undivided clock
    cur_req = "R11";
    run = 1'b0; wr(8'h00);
    kind = 2'd0; run = 1'b1;
    for (int i = 0; i < 65560; i++) begin
      step();
      if (ovf) ovfs++;
    end
    chk("overflow pulses", ovfs, 32'd1);

    // R1 reset clears sticky error and counter
    cur_req = "R1";
    run = 1'b0;
    rst_n = 1'b0;
    cycles(2);
    chk("reset err", {31'd0, err}, 32'h0);
    rst_n = 1'b1;
    cycles(2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule